// File: doc/BRIEF.md
# Fifteen-Level Inverter Gate Pattern Generator

This block produces the switch enables for a fifteen-level inverter. The inverter is an H-bridge fed through three source switches, with DC sources in the ratio 1:2:4. The block builds a digital sine reference from a phase accumulator and a quarter-wave table, and scales it by a modulation-index word. On every enabled clock it compares the reference magnitude against seven level-shifted triangular carriers. The count of carriers lying below the magnitude gives an output magnitude from 0 to 7. The sign of the reference picks which diagonal pair of the bridge conducts.

The magnitude is applied directly, in binary, to the three source switches. Because the source weights are binary, the bridge output takes one of fifteen values, from -7 to +7 units. When the polarity changes, the block turns off every bridge switch for one sample before the opposite diagonal pair is turned on. Alongside the gates, the block reports the signed level that those gates produce.

Top module: `mli_gate_gen`

## Requirements
- R1: While reset is asserted, all seven gate bits and the level are zero. The phase accumulator and the carrier counter are cleared, so the first enabled sample after reset uses phase 0 and carrier value 0.
- R2: The carrier value t runs 0,1,...,2^CAR_W-1,2^CAR_W-2,...,0,1,... and moves one step per enabled clock. The magnitude is the number of k in 0..6 for which k*2^CAR_W + t < A, where A is the reference magnitude.
- R3: The phase advances by PH_STEP, modulo 2^PH_W, on each enabled clock. The top two phase bits q select the quadrant. The next Q_W bits give i, with N = 2^Q_W. The table index is j = i when q is 0 or 2, and j = N - i when q is 1 or 3. A = (Q(j) * mod_idx) >> MI_W, where Q(j) = floor(FS*4*p / (5*N*N - p)), p = j*(2N - j) and FS = 7*2^CAR_W. The reference is negative when q is 2 or 3.
- R4: Gate bits 4, 5 and 6 enable the sources of weight 1, 2 and 4. Together they carry bits 0, 1 and 2 of the magnitude.
- R5: For a positive sample, gate bits 0 and 3 are high and bits 1 and 2 are low. For a negative sample this is reversed. The same holds at magnitude zero.
- R6: The diagonal pair on bits 0 and 3 is never on in the same cycle as the pair on bits 1 and 2. Within a pair, both bits are always equal.
- R7: When a sample's polarity differs from the polarity last driven, all seven gate bits and the level are zero for that sample. The next sample of the same polarity drives normally. Reset leaves the driven polarity positive.
- R8: The level output is a 4-bit two's-complement value. It equals +magnitude for positive samples, -magnitude for negative samples, and 0 for a blanking sample.
- R9: With en low, the phase, the carrier and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sample enable; advances reference and carrier |
| mod_idx | input | MI_W | Modulation index, reference scaled by mod_idx/2^MI_W |
| gate | output | 7 | Switch enables: bits 0,3 positive pair; 1,2 negative pair; 4..6 sources 1,2,4 |
| level | output | 4 | Signed output level, -7..+7 |

## Verification
Several rules are checked by assertions on every cycle: the two diagonal pairs are never on together, and both bits of a pair always agree. A source is never enabled while the bridge is off. The reported level always agrees with the gate bits. One pair is never turned on in the cycle right after the opposite pair. The carrier moves by exactly one step and turns at its peak, and the outputs hold while enable is low. Only the bench's sweeps can show the actual level values, because they depend on the sine table, the quadrant folding, the modulation scaling and the carrier count. To check these, the bench steps its own arithmetic model through whole reference periods at several modulation indices and compares every sample, including the blanking samples at zero crossings.

// File: rtl/mli_pkg.sv
package mli_pkg;
  localparam int unsigned NUM_GATES = 7;
  localparam int unsigned NUM_BANDS = 7;
  // gate bit positions
  localparam int unsigned G_POS_HI = 0;
  localparam int unsigned G_NEG_HI = 1;
  localparam int unsigned G_NEG_LO = 2;
  localparam int unsigned G_POS_LO = 3;
  localparam int unsigned G_SRC0   = 4;

  // Rational sine approximation over a quarter wave; j in 0..n, peak fs at j=n
  function automatic int unsigned qsine(int unsigned j, int unsigned n, int unsigned fs);
    int unsigned p;
    p = j * (2 * n - j);
    return (fs * 4 * p) / (5 * n * n - p);
  endfunction
endpackage

// File: rtl/mli_sine_ref.sv
module mli_sine_ref #(
  parameter int unsigned PH_W    = 10,
  parameter int unsigned Q_W     = 6,
  parameter int unsigned PH_STEP = 3,
  parameter int unsigned MI_W    = 8,
  parameter int unsigned FS      = 112,
  parameter int unsigned RW      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [MI_W-1:0] mod_idx,
  output logic [RW-1:0]   ref_abs,
  output logic            ref_neg
);
  localparam int unsigned N = 1 << Q_W;

  logic [PH_W-1:0] ph_q, ph_d;
  logic [1:0]      quad;
  logic [Q_W-1:0]  idx;
  logic [Q_W:0]    tbl_j;
  logic [RW-1:0]   tbl [0:N];
  logic [RW+MI_W-1:0] prod;

  always_comb begin
    ph_d = ph_q;
    if (en) ph_d = ph_q + PH_W'(PH_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  for (genvar g = 0; g <= N; g++) begin : g_tbl
    assign tbl[g] = RW'(mli_pkg::qsine(g, N, FS));
  end

  assign quad  = ph_q[PH_W-1 -: 2];
  assign idx   = Q_W'(ph_q >> (PH_W - 2 - Q_W));
  assign tbl_j = quad[0] ? ((Q_W+1)'(N) - {1'b0, idx}) : {1'b0, idx};
  assign prod  = (RW+MI_W)'(tbl[tbl_j]) * (RW+MI_W)'(mod_idx);
  assign ref_abs = RW'(prod >> MI_W);
  assign ref_neg = quad[1];

  // R3: phase moves only by the step, and only when enabled
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph_q == ($past(en) ? $past(ph_q) + PH_W'(PH_STEP) : $past(ph_q))));
endmodule

// File: rtl/mli_carrier.sv
module mli_carrier #(
  parameter int unsigned CAR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CAR_W-1:0] tri_val
);
  logic [CAR_W-1:0] tri_q, tri_d;
  logic             up_q, up_d;

  always_comb begin
    tri_d = tri_q;
    up_d  = up_q;
    if (en) begin
      if (up_q) begin
        if (&tri_q) begin
          up_d  = 1'b0;
          tri_d = tri_q - 1'b1;
        end else begin
          tri_d = tri_q + 1'b1;
        end
      end else begin
        if (tri_q == '0) begin
          up_d  = 1'b1;
          tri_d = tri_q + 1'b1;
        end else begin
          tri_d = tri_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q <= '0;
      up_q  <= 1'b1;
    end else begin
      tri_q <= tri_d;
      up_q  <= up_d;
    end
  end

  assign tri_val = tri_q;

  // R2: one step per enabled clock
  a_r2_tri_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((tri_q == $past(tri_q) + 1'b1) || (tri_q + 1'b1 == $past(tri_q))));
  // R2: turn around at the peak
  a_r2_tri_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&tri_q)) |=> (tri_q == CAR_W'((1 << CAR_W) - 2)));
endmodule

// File: rtl/mli_level_map.sv
module mli_level_map #(
  parameter int unsigned CAR_W = 4,
  parameter int unsigned RW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RW-1:0]     ref_abs,
  input  logic              ref_neg,
  input  logic [CAR_W-1:0]  tri_val,
  output logic [6:0]        gate_q,
  output logic signed [3:0] level_q
);
  import mli_pkg::*;
  localparam int unsigned BAND = 1 << CAR_W;

  logic [NUM_BANDS-1:0] above;
  logic [2:0]           mag;
  logic                 neg_q, neg_d, blank;
  logic [6:0]           gate_d;
  logic signed [3:0]    level_d;

  always_comb begin
    for (int k = 0; k < NUM_BANDS; k++) begin
      above[k] = (32'(k * BAND) + 32'(tri_val)) < 32'(ref_abs);
    end
  end

  always_comb begin
    mag = '0;
    for (int k = 0; k < NUM_BANDS; k++) mag = mag + 3'(above[k]);
  end

  assign blank = (ref_neg != neg_q);

  always_comb begin
    gate_d  = gate_q;
    level_d = level_q;
    neg_d   = neg_q;
    if (en) begin
      neg_d = ref_neg;
      if (blank) begin
        gate_d  = '0;
        level_d = '0;
      end else begin
        gate_d = '0;
        gate_d[G_SRC0 +: 3] = mag;
        if (ref_neg) begin
          gate_d[G_NEG_HI] = 1'b1;
          gate_d[G_NEG_LO] = 1'b1;
          level_d = -$signed({1'b0, mag});
        end else begin
          gate_d[G_POS_HI] = 1'b1;
          gate_d[G_POS_LO] = 1'b1;
          level_d = $signed({1'b0, mag});
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      level_q <= '0;
      neg_q   <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      level_q <= level_d;
      neg_q   <= neg_d;
    end
  end

  // R6: pairs complementary and internally consistent
  a_r6_pairs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((gate_q[G_POS_HI] | gate_q[G_POS_LO]) && (gate_q[G_NEG_HI] | gate_q[G_NEG_LO])));
  a_r6_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q[G_POS_HI] == gate_q[G_POS_LO]) && (gate_q[G_NEG_HI] == gate_q[G_NEG_LO]));
  // R4: no source enabled while the bridge is off
  a_r4_src_needs_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (|gate_q[G_SRC0 +: 3]) |-> (gate_q[G_POS_HI] | gate_q[G_NEG_HI]));
  // R8: reported level agrees with the gates
  a_r8_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == (gate_q[G_NEG_HI] ? -$signed({1'b0, gate_q[G_SRC0 +: 3]})
                                 : $signed({1'b0, gate_q[G_SRC0 +: 3]})));
  // R7: no direct handover between pairs
  a_r7_blank_pos_to_neg: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q[G_POS_HI] |=> !gate_q[G_NEG_HI]);
  a_r7_blank_neg_to_pos: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q[G_NEG_HI] |=> !gate_q[G_POS_HI]);
  // R9: outputs hold while disabled
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(gate_q) && $stable(level_q)));
endmodule

// File: rtl/mli_gate_gen.sv
module mli_gate_gen #(
  parameter int unsigned PH_W    = 10,
  parameter int unsigned Q_W     = 6,
  parameter int unsigned PH_STEP = 3,
  parameter int unsigned CAR_W   = 4,
  parameter int unsigned MI_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MI_W-1:0]   mod_idx,
  output logic [6:0]        gate,
  output logic signed [3:0] level
);
  localparam int unsigned FS = mli_pkg::NUM_BANDS * (1 << CAR_W);
  localparam int unsigned RW = $clog2(FS + 1);

  logic [RW-1:0]    ref_abs;
  logic             ref_neg;
  logic [CAR_W-1:0] tri_val;

  mli_sine_ref #(
    .PH_W(PH_W), .Q_W(Q_W), .PH_STEP(PH_STEP), .MI_W(MI_W), .FS(FS), .RW(RW)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .en(en), .mod_idx(mod_idx),
    .ref_abs(ref_abs), .ref_neg(ref_neg)
  );

  mli_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(en), .tri_val(tri_val)
  );

  mli_level_map #(.CAR_W(CAR_W), .RW(RW)) u_map (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_abs(ref_abs), .ref_neg(ref_neg),
    .tri_val(tri_val), .gate_q(gate), .level_q(level)
  );
endmodule

// File: tb/test_mli_gate_gen.sv
module test_mli_gate_gen;
  localparam int CLK_P = 10;
  localparam int PH_W = 10, Q_W = 6, STEP = 3, CAR_W = 4, MI_W = 8;
  localparam int N = 1 << Q_W;
  localparam int BAND = 1 << CAR_W;
  localparam int FS = 7 * BAND;

  logic clk = 1'b0;
  logic rst_n, en;
  logic [MI_W-1:0] mod_idx;
  logic [6:0] gate;
  logic signed [3:0] level;

  int n_chk = 0, n_fail = 0, n_blank = 0;
  bit done = 0;

  // model state
  int ph, tv, up, pol;

  always #(CLK_P/2) clk = ~clk;

  mli_gate_gen #(.PH_W(PH_W), .Q_W(Q_W), .PH_STEP(STEP), .CAR_W(CAR_W), .MI_W(MI_W))
    i_mli_gate_gen (.clk(clk), .rst_n(rst_n), .en(en), .mod_idx(mod_idx),
                    .gate(gate), .level(level));

  function automatic int qs(int j);
    int p;
    p = j * (2 * N - j);
    return (FS * 4 * p) / (5 * N * N - p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one enabled sample: drive at negedge, compare after the edge
  task automatic step_on();
    int q, i, j, a, neg, mag, eg, el;
    @(negedge clk); en = 1'b1;
    @(posedge clk); #1;
    q = (ph >> (PH_W - 2)) & 3;
    i = (ph >> (PH_W - 2 - Q_W)) & (N - 1);
    j = (q & 1) ? N - i : i;                     // R3 quadrant folding
    a = (qs(j) * int'(mod_idx)) >> MI_W;          // R3 scaling
    neg = q >> 1;
    mag = 0;
    for (int k = 0; k < 7; k++) if (k * BAND + tv < a) mag++;   // R2
    if (neg != pol) begin
      eg = 0; el = 0; pol = neg; n_blank++;
      chk(gate == 7'd0, "R7 blank gates", int'(gate), 0);
    end else begin
      eg = (mag << 4) | (neg ? 6 : 9);
      el = neg ? -mag : mag;
      chk(gate[6:4] == 3'(mag), "R4 source bits", int'(gate[6:4]), mag);
      chk(gate[3:0] == 4'(neg ? 6 : 9), "R5 bridge bits", int'(gate[3:0]), neg ? 6 : 9);
    end
    chk(int'(level) == el, "R8 level", int'(level), el);
    chk(!((gate[0] | gate[3]) && (gate[1] | gate[2])), "R6 pairs", int'(gate), eg);
    ph = (ph + STEP) % (1 << PH_W);
    if (up != 0) begin
      if (tv == BAND - 1) begin up = 0; tv = tv - 1; end else tv = tv + 1;
    end else begin
      if (tv == 0) begin up = 1; tv = tv + 1; end else tv = tv - 1;
    end
  endtask

  task automatic hold_test(int cycles);
    logic [6:0] g0;
    logic signed [3:0] l0;
    g0 = gate; l0 = level;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); en = 1'b0;
      @(posedge clk); #1;
      chk(gate == g0, "R9 gate hold", int'(gate), int'(g0));
      chk(level == l0, "R9 level hold", int'(level), int'(l0));
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; mod_idx = 8'd255;
    ph = 0; tv = 0; up = 1; pol = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(gate == 7'd0, "R1 reset gates", int'(gate), 0);
    chk(level == 4'sd0, "R1 reset level", int'(level), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: first sample uses phase 0, carrier 0 -> magnitude 0, positive pair
    step_on();
    chk(gate == 7'b0001001, "R1 first sample", int'(gate), 9);
    for (int s = 0; s < 700; s++) step_on();          // full scale, R2 R3
    hold_test(5);                                     // R9
    mod_idx = 8'd128;
    for (int s = 0; s < 700; s++) step_on();
    mod_idx = 8'd40;
    for (int s = 0; s < 700; s++) step_on();
    hold_test(3);
    mod_idx = 8'd0;
    for (int s = 0; s < 400; s++) step_on();
    mod_idx = 8'd200;
    for (int s = 0; s < 700; s++) step_on();
    chk(n_blank >= 4, "R7 blanking seen", n_blank, 4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule